// File: doc/BRIEF.md
# Transition Pulse Encoder with Periodic Refresh

This block drives the transmit side of one isolated logic channel. It samples a logic input, and each change of that input becomes a short burst on a single pulse line: two narrow pulses when the input is now high, one narrow pulse when it is now low. A receiver that toggles a bistable latch from these bursts can rebuild the level on the far side.

A steady input still produces traffic. Once the line has carried no code for an idle timeout, the block resends the code for the present level, then repeats it on a fixed refresh period. A receiver that missed a burst, or was powered up late, therefore converges to the correct level. A power-good qualifier silences the line and clears all timing state while the sending side is not trusted.

All timings are counted in clock cycles: pulse width, the low gap inside a pair, a guard interval that separates consecutive codes, the idle timeout and the refresh period.

Top module: `pcode_tx`

## Requirements
- R1: While `rst` is high and in the cycle after it, `pulse_out` is 0. No code is pending and the refresh timer is zero. With `din` held low, the first code after reset release is a single refresh pulse sampled high exactly IDLE_CYC cycles after release.
- R2: A high-level code is a pair: `pulse_out` high for PULSE_W cycles, low for PAIR_GAP cycles, then high for PULSE_W cycles.
- R3: A low-level code is one pulse of PULSE_W cycles on `pulse_out`.
- R4: After `din` changes, the first pulse of its code is high in the third clock cycle. Two of those cycles are synchronizer stages and one is the launch register.
- R5: While `din` is steady, no code is sent until the idle timeout expires. The first refresh code starts IDLE_CYC cycles after the most recent code launch, and it encodes the current level. Every launched code restarts this timer.
- R6: Once refreshing, refresh codes start every REFRESH_CYC cycles for as long as `din` stays steady.
- R7: After the last pulse of a code, the line stays low for at least GUARD_CYC+1 cycles before the next code can begin.
- R8: An input change that arrives while a code or its guard is in progress is held. One code for the latest synchronized level is sent when the line is free. Several changes in that time give a single code.
- R9: While `pwr_ok` is low, `pulse_out` is 0 from the next cycle on. Pending changes are dropped and the refresh timer is held at zero. After `pwr_ok` returns with `din` steady, the first code is a refresh IDLE_CYC cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Logic level to transmit, asynchronous to `clk` |
| pwr_ok | input | 1 | High when the sending side is powered and valid |
| pulse_out | output | 1 | Coded pulse line, one pulse per high cycle |

## Verification
A corrupted phase counter or state register shows at the port within a few cycles. It appears as a pulse wider than PULSE_W, a pair whose inner gap is shorter than PAIR_GAP, or a single pulse where a pair was due. A lost pending flag shows up as a missing code three cycles after a change, or after the guard of the code in progress. A stuck or miscounted refresh timer shows no sooner than IDLE_CYC or REFRESH_CYC cycles. It appears as a code that starts early or late, or as a gap longer than the timeout, which the bound deadline check catches in the cycle the limit is passed.

// File: rtl/pcode_pkg.sv
package pcode_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_HI1   = 3'd1,
        SQ_GAP   = 3'd2,
        SQ_HI2   = 3'd3,
        SQ_GUARD = 3'd4
    } shp_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pcode_sync.sv
module pcode_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic d_sync
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_in};
    end

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pcode_sched.sv
module pcode_sched
    import pcode_pkg::*;
#(
    parameter int IDLE_CYC    = 125,
    parameter int REFRESH_CYC = 104
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_ok,
    input  logic lvl,
    input  logic busy,
    output logic launch,
    output logic code_hi
);
    localparam int LIM_MAX = imax(IDLE_CYC, REFRESH_CYC);
    localparam int CW      = $clog2(LIM_MAX + 1);
    localparam logic [CW-1:0] IDLE_END = CW'(IDLE_CYC - 1);
    localparam logic [CW-1:0] REF_END  = CW'(REFRESH_CYC - 1);

    typedef struct packed {
        logic          lvl_prev;
        logic          pend;
        logic          in_ref;
        logic [CW-1:0] cnt;
    } sched_t;

    sched_t          q, d;
    logic            edge_seen, want_edge, expired;
    logic [CW-1:0]   limit;

    always_comb begin
        d          = q;
        launch     = 1'b0;
        code_hi    = lvl;
        edge_seen  = lvl ^ q.lvl_prev;
        want_edge  = q.pend | edge_seen;
        limit      = q.in_ref ? REF_END : IDLE_END;
        expired    = (q.cnt >= limit);
        d.lvl_prev = lvl;

        if (!pwr_ok) begin
            d.pend   = 1'b0;
            d.in_ref = 1'b0;
            d.cnt    = '0;
        end else if (want_edge && !busy) begin
            launch   = 1'b1;
            d.pend   = 1'b0;
            d.in_ref = 1'b0;
            d.cnt    = '0;
        end else if (expired && !busy) begin
            launch   = 1'b1;
            d.pend   = 1'b0;
            d.in_ref = 1'b1;
            d.cnt    = '0;
        end else begin
            d.pend = want_edge;
            if (!expired) d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/pcode_shaper.sv
module pcode_shaper
    import pcode_pkg::*;
#(
    parameter int PULSE_W   = 1,
    parameter int PAIR_GAP  = 2,
    parameter int GUARD_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_ok,
    input  logic launch,
    input  logic code_hi,
    output logic pulse,
    output logic busy
);
    localparam int PH_MAX = imax(imax(PULSE_W, PAIR_GAP), GUARD_CYC);
    localparam int PHW    = $clog2(PH_MAX + 1);
    localparam logic [PHW-1:0] HI_END  = PHW'(PULSE_W - 1);
    localparam logic [PHW-1:0] GAP_END = PHW'(PAIR_GAP - 1);
    localparam logic [PHW-1:0] GRD_END = PHW'(GUARD_CYC - 1);

    typedef struct packed {
        shp_state_e     st;
        logic [PHW-1:0] ph;
        logic           pair;
    } shp_t;

    shp_t q, d;

    always_comb begin
        d = q;
        unique case (q.st)
            SQ_IDLE: begin
                if (launch) begin
                    d.st   = SQ_HI1;
                    d.ph   = '0;
                    d.pair = code_hi;
                end
            end
            SQ_HI1: begin
                if (q.ph == HI_END) begin
                    d.ph = '0;
                    d.st = q.pair ? SQ_GAP : SQ_GUARD;
                end else begin
                    d.ph = q.ph + 1'b1;
                end
            end
            SQ_GAP: begin
                if (q.ph == GAP_END) begin
                    d.ph = '0;
                    d.st = SQ_HI2;
                end else begin
                    d.ph = q.ph + 1'b1;
                end
            end
            SQ_HI2: begin
                if (q.ph == HI_END) begin
                    d.ph = '0;
                    d.st = SQ_GUARD;
                end else begin
                    d.ph = q.ph + 1'b1;
                end
            end
            SQ_GUARD: begin
                if (q.ph == GRD_END) begin
                    d.ph = '0;
                    d.st = SQ_IDLE;
                end else begin
                    d.ph = q.ph + 1'b1;
                end
            end
            default: begin
                d.st = SQ_IDLE;
                d.ph = '0;
            end
        endcase

        if (!pwr_ok) begin
            d.st   = SQ_IDLE;
            d.ph   = '0;
            d.pair = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '{st: SQ_IDLE, ph: '0, pair: 1'b0};
        else     q <= d;
    end

    assign pulse = (q.st == SQ_HI1) || (q.st == SQ_HI2);
    assign busy  = (q.st != SQ_IDLE);
endmodule

// File: rtl/pcode_tx.sv
module pcode_tx #(
    parameter int SYNC_STAGES = 2,
    parameter int PULSE_W     = 1,
    parameter int PAIR_GAP    = 2,
    parameter int GUARD_CYC   = 4,
    parameter int IDLE_CYC    = 125,
    parameter int REFRESH_CYC = 104
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic pwr_ok,
    output logic pulse_out
);
    logic lvl_w, launch_w, code_hi_w, busy_w, pulse_w;

    pcode_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d_in   (din),
        .d_sync (lvl_w)
    );

    pcode_sched #(
        .IDLE_CYC    (IDLE_CYC),
        .REFRESH_CYC (REFRESH_CYC)
    ) u_sched (
        .clk     (clk),
        .rst     (rst),
        .pwr_ok  (pwr_ok),
        .lvl     (lvl_w),
        .busy    (busy_w),
        .launch  (launch_w),
        .code_hi (code_hi_w)
    );

    pcode_shaper #(
        .PULSE_W   (PULSE_W),
        .PAIR_GAP  (PAIR_GAP),
        .GUARD_CYC (GUARD_CYC)
    ) u_shaper (
        .clk     (clk),
        .rst     (rst),
        .pwr_ok  (pwr_ok),
        .launch  (launch_w),
        .code_hi (code_hi_w),
        .pulse   (pulse_w),
        .busy    (busy_w)
    );

    assign pulse_out = pulse_w;
endmodule

// File: rtl/pcode_tx_chk.sv
module pcode_tx_chk #(
    parameter int PULSE_W     = 1,
    parameter int PAIR_GAP    = 2,
    parameter int IDLE_CYC    = 125,
    parameter int REFRESH_CYC = 104
) (
    input logic clk,
    input logic rst,
    input logic pwr_ok,
    input logic pulse_out,
    input logic launch,
    input logic busy
);
    localparam int LIM_MAX = (IDLE_CYC > REFRESH_CYC) ? IDLE_CYC : REFRESH_CYC;
    localparam int CW      = $clog2(LIM_MAX + 2);
    localparam logic [CW-1:0] LIM_V = CW'(LIM_MAX);

    logic [CW-1:0] since_q;
    logic [7:0]    hi_q, lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '0;
            hi_q    <= '0;
            lo_q    <= 8'hFF;
        end else begin
            if (!pwr_ok || launch)  since_q <= '0;
            else if (since_q != '1) since_q <= since_q + 1'b1;
            if (pulse_out) begin
                lo_q <= '0;
                if (hi_q != 8'hFF) hi_q <= hi_q + 1'b1;
            end else begin
                hi_q <= '0;
                if (lo_q != 8'hFF) lo_q <= lo_q + 1'b1;
            end
        end
    end

    assert_quiet_unpowered_R9: assert property (@(posedge clk) disable iff (rst)
        !pwr_ok |=> !pulse_out);

    assert_launch_only_free_R8: assert property (@(posedge clk) disable iff (rst)
        launch |-> !busy);

    assert_refresh_deadline_R5: assert property (@(posedge clk) disable iff (rst)
        pwr_ok |-> (since_q < LIM_V));

    assert_pulse_width_R2: assert property (@(posedge clk) disable iff (rst)
        pulse_out |-> (hi_q < 8'(PULSE_W)));

    assert_gap_before_rise_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_out) |-> (lo_q >= 8'(PAIR_GAP)));
endmodule

bind pcode_tx pcode_tx_chk #(
    .PULSE_W     (PULSE_W),
    .PAIR_GAP    (PAIR_GAP),
    .IDLE_CYC    (IDLE_CYC),
    .REFRESH_CYC (REFRESH_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pwr_ok    (pwr_ok),
    .pulse_out (pulse_out),
    .launch    (launch_w),
    .busy      (busy_w)
);

// File: tb/tb_pcode_tx.sv
`timescale 1ns/1ps
module tb_pcode_tx;
    localparam int PW   = 1;
    localparam int GAP  = 2;
    localparam int GRD  = 4;
    localparam int IDLE = 125;
    localparam int REF  = 104;

    localparam int NV = 7;
    localparam int T_LVL  [NV] = '{1, 0, 0, 1, 1, 1, 0};
    localparam int T_HOLD [NV] = '{50, 50, 50, 50, 50, 300, 300};
    localparam int T_RISE [NV] = '{2, 1, 0, 2, 0, 6, 3};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic pwr_ok = 1'b1;
    logic pulse_out;

    int n_chk = 0;
    int n_bad = 0;
    int kc = 0;
    int nr = 0;
    int nh = 0;
    int rt [16];
    logic prev = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pcode_tx #(
        .SYNC_STAGES (2),
        .PULSE_W     (PW),
        .PAIR_GAP    (GAP),
        .GUARD_CYC   (GRD),
        .IDLE_CYC    (IDLE),
        .REFRESH_CYC (REF)
    ) dut (
        .clk       (clk),
        .rst       (rst),
        .din       (din),
        .pwr_ok    (pwr_ok),
        .pulse_out (pulse_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        kc++;
        if (pulse_out) nh++;
        if (pulse_out && !prev) begin
            if (nr < 16) rt[nr] = kc;
            nr++;
        end
        prev = pulse_out;
    endtask

    task automatic open_win();
        kc = 0;
        nr = 0;
        nh = 0;
        for (int i = 0; i < 16; i++) rt[i] = -1;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        // R1: reset state and first refresh after release
        repeat (5) step();
        chk("R1 reset output", int'(pulse_out), 0);
        open_win();
        rst = 1'b0;
        run(130);
        chk("R1 first refresh time", rt[0], IDLE);
        chk("R1 single low refresh", nh, 1);

        // table: R4/R5 steady, R2/R3 codes, R6 refresh repeats
        for (int v = 0; v < NV; v++) begin
            open_win();
            din = T_LVL[v][0];
            run(T_HOLD[v]);
            chk($sformatf("R5 R6 table row %0d rises", v), nr, T_RISE[v]);
        end

        // R4 R2: latency and pair shape
        open_win();
        din = 1'b1;
        run(20);
        chk("R4 pair first rise", rt[0], 3);
        chk("R2 pair second rise", rt[1], 3 + PW + GAP);
        chk("R2 pair high cycles", nh, 2 * PW);
        run(20);

        // R3: falling edge single pulse
        open_win();
        din = 1'b0;
        run(20);
        chk("R3 single rise", rt[0], 3);
        chk("R3 single count", nr, 1);

        // R8 R7: change during a pair is queued
        open_win();
        din = 1'b1;
        for (int i = 1; i <= 30; i++) begin
            step();
            if (i == 4) din = 1'b0;
        end
        chk("R8 queued count", nr, 3);
        chk("R7 queued rise after guard", rt[2], 12);
        chk("R8 queued single", nh, 3);

        // R8: back and forth changes coalesce into one code of latest level
        open_win();
        din = 1'b1;
        for (int i = 1; i <= 30; i++) begin
            step();
            if (i == 4) din = 1'b0;
            if (i == 5) din = 1'b1;
        end
        chk("R8 coalesced rises", nr, 4);
        chk("R8 coalesced third", rt[2], 12);
        chk("R8 coalesced fourth", rt[3], 15);

        // R5 R6: exact refresh timing after a falling edge code
        open_win();
        din = 1'b0;
        run(240);
        chk("R5 edge code time", rt[0], 3);
        chk("R5 first refresh time", rt[1], 3 + IDLE);
        chk("R6 second refresh time", rt[2], 3 + IDLE + REF);
        chk("R5 low refresh singles", nh, 3);

        // R9: silent and frozen while unpowered
        open_win();
        pwr_ok = 1'b0;
        for (int i = 1; i <= 400; i++) begin
            step();
            if (i % 30 == 0 && i < 300) din = ~din;
        end
        chk("R9 no pulses unpowered", nr, 0);
        din = 1'b1;
        run(10);
        open_win();
        pwr_ok = 1'b1;
        run(140);
        chk("R9 restore first refresh", rt[0], IDLE);
        chk("R9 restore pair", rt[1], IDLE + PW + GAP);
        chk("R9 restore count", nr, 2);

        // R9: drop mid code silences the line next cycle
        open_win();
        din = 1'b0;
        run(3);
        chk("R9 code started", int'(pulse_out), 1);
        pwr_ok = 1'b0;
        run(1);
        chk("R9 silenced next cycle", int'(pulse_out), 0);
        pwr_ok = 1'b1;

        // R1: reset mid code clears output
        din = 1'b1;
        open_win();
        run(3);
        rst = 1'b1;
        run(1);
        chk("R1 reset mid code", int'(pulse_out), 0);
        run(2);
        rst = 1'b0;

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule